// File: doc/BRIEF.md
# RV32I Immediate Extraction Unit

This combinational unit takes a 32-bit RV32I instruction word and returns the 32-bit immediate operand that the datapath uses. The bits of an immediate are scattered across the instruction word, and where they sit depends on the instruction format. The unit gathers them back into numeric order for the format chosen by a 3-bit selector. It then fills the upper bits with instruction bit 31, with zeros, or leaves them as they are. Which fill applies depends on the format and on a zero-extend select.

The decoder drives the format selector from the opcode. The output feeds the ALU operand multiplexer and the branch/jump target adder. The unit holds no state and has no clock. The result appears in the same cycle as the instruction word.

The design has two parts. A field-gather stage builds the ordered field and a mask of the bits the format owns. An extension stage fills the bits outside that mask.

Top module: `imm_unscramble`

## Requirements
- R1: With format code 0 (I) and zero-extend clear, the output is instr[31:20] sign-extended from bit 11, using instr[31].
- R2: With format code 0 (I) and zero-extend set, output bits [11:0] equal instr[31:20] and bits [31:12] are zero.
- R3: With format code 1 (S), the output is {instr[31:25], instr[11:7]} sign-extended from bit 11.
- R4: With format code 2 (B), the output is {instr[31], instr[7], instr[30:25], instr[11:8], 0} sign-extended from bit 12. Bit 0 is always zero.
- R5: With format code 3 (U), the output is {instr[31:12], 12 zero bits}, with no further extension.
- R6: With format code 4 (J), the output is {instr[31], instr[19:12], instr[20], instr[30:21], 0} sign-extended from bit 20. Bit 0 is always zero.
- R7: The zero-extend select has no effect with format codes 1 to 4.
- R8: Format codes 5, 6 and 7 are unused and give an all-zero output, whatever the instruction word is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| fmt_i | input | 3 | Format code: 0 I, 1 S, 2 B, 3 U, 4 J, 5-7 unused |
| zext_i | input | 1 | Zero-extend select, honoured for format I only |
| imm_o | output | 32 | Reassembled and extended immediate |

## Verification
Each format is driven with its most negative and most positive immediate. The most negative value (sign bit alone) shows whether the fill runs from the correct bit. The most positive value (every other field bit set) shows whether each slice lands in its own position without overlap.

Single-bit instruction words find slices that were swapped, such as instr[20] and instr[7]. Odd branch and jump patterns, which have register-field noise set, confirm that bit 0 stays zero.

The zero-extend select is toggled across all formats, which separates I-only zero extension from a global one. Unused codes are driven with an all-ones word.

// File: rtl/imm_pkg.sv
package imm_pkg;
    localparam int XLEN  = 32;
    localparam int FMT_W = 3;

    typedef enum logic [FMT_W-1:0] {
        FMT_I = 3'd0,
        FMT_S = 3'd1,
        FMT_B = 3'd2,
        FMT_U = 3'd3,
        FMT_J = 3'd4
    } imm_fmt_e;

    // Number of low bits owned by the format's field (before fill).
    function automatic int unsigned field_bits(input logic [FMT_W-1:0] f);
        case (f)
            FMT_I, FMT_S: field_bits = 12;
            FMT_B:        field_bits = 13;
            FMT_J:        field_bits = 21;
            default:      field_bits = XLEN;
        endcase
    endfunction
endpackage

// File: rtl/imm_field_gather.sv
module imm_field_gather
    import imm_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]     instr_i,
    input  logic [FMT_W-1:0] fmt_i,
    output logic [W-1:0]     field_o,
    output logic [W-1:0]     own_mask_o,
    output logic             fmt_ok_o
);
    localparam int UPPER_W = W - 12;

    logic unused_opcode;
    assign unused_opcode = ^instr_i[6:0];

    // Mask of bit positions the format fills itself, computed per bit.
    for (genvar b = 0; b < W; b++) begin : g_mask
        assign own_mask_o[b] = (b < field_bits(fmt_i));
    end

    always_comb begin
        field_o  = '0;
        fmt_ok_o = 1'b1;
        unique case (fmt_i)
            FMT_I: field_o[11:0] = instr_i[31:20];
            FMT_S: field_o[11:0] = {instr_i[31:25], instr_i[11:7]};
            FMT_B: field_o[12:0] = {instr_i[31], instr_i[7], instr_i[30:25],
                                    instr_i[11:8], 1'b0};
            FMT_U: field_o       = {instr_i[31:12], {(W-UPPER_W){1'b0}}};
            FMT_J: field_o[20:0] = {instr_i[31], instr_i[19:12], instr_i[20],
                                    instr_i[30:21], 1'b0};
            default: fmt_ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/imm_sign_fill.sv
module imm_sign_fill
    import imm_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] field_i,
    input  logic [W-1:0] own_mask_i,
    input  logic         sign_i,
    input  logic         fill_en_i,
    output logic [W-1:0] imm_o
);
    logic [W-1:0] fill;

    always_comb begin
        fill  = (fill_en_i && sign_i) ? ~own_mask_i : '0;
        imm_o = field_i | fill;
    end
endmodule

// File: rtl/imm_unscramble.sv
module imm_unscramble
    import imm_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [2:0]  fmt_i,
    input  logic        zext_i,
    output logic [31:0] imm_o
);
    logic [XLEN-1:0] field;
    logic [XLEN-1:0] own_mask;
    logic            fmt_ok;
    logic            fill_en;

    imm_field_gather #(.W(XLEN)) u_gather (
        .instr_i    (instr_i),
        .fmt_i      (fmt_i),
        .field_o    (field),
        .own_mask_o (own_mask),
        .fmt_ok_o   (fmt_ok)
    );

    // Zero extension is honoured only for the I format.
    always_comb begin
        fill_en = fmt_ok && (fmt_i != FMT_U) && !((fmt_i == FMT_I) && zext_i);
    end

    imm_sign_fill #(.W(XLEN)) u_fill (
        .field_i    (field),
        .own_mask_i (own_mask),
        .sign_i     (instr_i[XLEN-1]),
        .fill_en_i  (fill_en),
        .imm_o      (imm_o)
    );
endmodule

// File: rtl/imm_unscramble_chk.sv
module imm_unscramble_chk (
    input logic [31:0] instr_i,
    input logic [2:0]  fmt_i,
    input logic        zext_i,
    input logic [31:0] imm_o
);
    always_comb begin
        if (fmt_i == 3'd0) begin
            p_i_field_r1: assert (imm_o[11:0] == instr_i[31:20])
                else $error("I field wrong");
            if (!zext_i) begin
                p_i_fill_r1: assert (imm_o[31:12] == {20{instr_i[31]}})
                    else $error("I sign fill wrong");
            end else begin
                p_i_zero_r2: assert (imm_o[31:12] == 20'd0)
                    else $error("I zero fill wrong");
            end
        end
        if (fmt_i == 3'd1) begin
            p_s_low_r3: assert (imm_o[4:0] == instr_i[11:7])
                else $error("S low slice wrong");
        end
        if (fmt_i == 3'd2) begin
            p_b_even_r4: assert (!imm_o[0] && imm_o[11] == instr_i[7])
                else $error("B bit0/bit11 wrong");
        end
        if (fmt_i == 3'd3) begin
            p_u_low_zero_r5: assert (imm_o[11:0] == 12'd0 && imm_o[31:12] == instr_i[31:12])
                else $error("U wrong");
        end
        if (fmt_i == 3'd4) begin
            p_j_even_r6: assert (!imm_o[0] && imm_o[11] == instr_i[20])
                else $error("J bit0/bit11 wrong");
        end
        if (fmt_i != 3'd0 && fmt_i < 3'd5) begin
            p_sign_top_r7: assert (imm_o[31] == instr_i[31])
                else $error("top bit not sign");
        end
        if (fmt_i > 3'd4) begin
            p_bad_fmt_zero_r8: assert (imm_o == 32'd0)
                else $error("unused code not zero");
        end
    end
endmodule

bind imm_unscramble imm_unscramble_chk u_chk (
    .instr_i (instr_i),
    .fmt_i   (fmt_i),
    .zext_i  (zext_i),
    .imm_o   (imm_o)
);

// File: tb/imm_unscramble_tb.sv
module imm_unscramble_tb;
    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [2:0]  fmt;
    logic        zext;
    logic [31:0] imm;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    imm_unscramble u_dut (
        .instr_i (instr),
        .fmt_i   (fmt),
        .zext_i  (zext),
        .imm_o   (imm)
    );

    // {instr, fmt, zext, expected}
    localparam int NV = 24;
    localparam logic [67:0] VEC [NV] = '{
        {32'hFFF00093, 3'd0, 1'b0, 32'hFFFFFFFF},  // R1 -1
        {32'h7FF00093, 3'd0, 1'b0, 32'h000007FF},  // R1 max
        {32'h80000093, 3'd0, 1'b0, 32'hFFFFF800},  // R1 min
        {32'hFFF00093, 3'd0, 1'b1, 32'h00000FFF},  // R2
        {32'h80000093, 3'd0, 1'b1, 32'h00000800},  // R2
        {32'h7FF00093, 3'd0, 1'b1, 32'h000007FF},  // R2
        {32'h80000023, 3'd1, 1'b0, 32'hFFFFF800},  // R3 min
        {32'h7E000FA3, 3'd1, 1'b0, 32'h000007FF},  // R3 max
        {32'h00000EA3, 3'd1, 1'b0, 32'h0000001D},  // R3 low slice
        {32'h80000063, 3'd2, 1'b0, 32'hFFFFF000},  // R4 min
        {32'h7E000FE3, 3'd2, 1'b0, 32'h00000FFE},  // R4 max
        {32'h00F00163, 3'd2, 1'b0, 32'h00000002},  // R4 odd/noise
        {32'h000000E3, 3'd2, 1'b0, 32'h00000800},  // R4 instr[7]
        {32'hFFFFF0B7, 3'd3, 1'b0, 32'hFFFFF000},  // R5
        {32'h123450B7, 3'd3, 1'b0, 32'h12345000},  // R5
        {32'h8000006F, 3'd4, 1'b0, 32'hFFF00000},  // R6 min
        {32'h7FFFF06F, 3'd4, 1'b0, 32'h000FFFFE},  // R6 max
        {32'h0010006F, 3'd4, 1'b0, 32'h00000800},  // R6 instr[20]
        {32'h80000023, 3'd1, 1'b1, 32'hFFFFF800},  // R7 S
        {32'h80000063, 3'd2, 1'b1, 32'hFFFFF000},  // R7 B
        {32'hFFFFF0B7, 3'd3, 1'b1, 32'hFFFFF000},  // R7 U
        {32'h8000006F, 3'd4, 1'b1, 32'hFFF00000},  // R7 J
        {32'hFFFFFFFF, 3'd5, 1'b0, 32'h00000000},  // R8
        {32'hFFFFFFFF, 3'd7, 1'b1, 32'h00000000}   // R8
    };
    localparam logic [15:0] TAG [NV] = '{
        "R1","R1","R1","R2","R2","R2","R3","R3","R3","R4","R4","R4",
        "R4","R5","R5","R6","R6","R6","R7","R7","R7","R7","R8","R8"
    };

    task automatic apply(input logic [31:0] i, input logic [2:0] f,
                         input logic z, input logic [31:0] exp,
                         input logic [15:0] tag);
        @(posedge clk);
        instr = i; fmt = f; zext = z;
        @(negedge clk);
        n_chk++;
        if (imm !== exp) begin
            n_bad++;
            $display("FAIL %s instr=%h fmt=%0d zext=%0b got=%h exp=%h",
                     tag, i, f, z, imm, exp);
        end
    endtask

    initial begin
        instr = '0; fmt = '0; zext = 1'b0;
        // Initial state: all-zero word in format I gives zero (R1).
        apply(32'h0, 3'd0, 1'b0, 32'h0, "R1");
        for (int k = 0; k < NV; k++)
            apply(VEC[k][67:36], VEC[k][35:33], VEC[k][32], VEC[k][31:0], TAG[k]);
        // Directed: unused code 6 with noise (R8).
        apply(32'hA5A5A5A5, 3'd6, 1'b1, 32'h0, "R8");
        // Directed: zext toggled on same J word changes nothing (R7).
        apply(32'h7FFFF06F, 3'd4, 1'b1, 32'h000FFFFE, "R7");
        // Directed: zext back to 0 on I restores sign fill (R1).
        apply(32'h80000093, 3'd0, 1'b1, 32'h00000800, "R2");
        apply(32'h80000093, 3'd0, 1'b0, 32'hFFFFF800, "R1");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule